// File: doc/BRIEF.md
# Asynchronous Parallel Host-Bus Master

This block turns single internal read or write requests into strobed cycles on an external parallel bus. The bus carries 8-bit or 16-bit data with separate address and data lines. No bus clock is driven out: the external device sees only a cycle qualifier (an active-low chip select, an active-high address latch enable, or both) and separate active-low write and read strobes, all driven from registers.

Each cycle has one setup clock with the qualifier active. The strobe then lasts one clock plus two clocks for each configured wait state, with separate wait-state settings for reads and writes. One hold clock follows before the qualifier is released and the request is acknowledged. A word mode places bytes and half-words on their natural lanes of the 32-bit bus instead of the low lanes. In 16-bit mode, optional active-low byte selects mark the valid bytes. A FIFO sub-mode holds a cycle back while an external FIFO reports full (for writes) or empty (for reads), so the requester stalls. Between cycles the address and write-data outputs keep their last values.

Top module: `hostbus_master`

## Requirements
- R1: After synchronous reset, bus_cs_n=1, bus_ale=0, bus_wr_n=1, bus_rd_n=1, bus_bsel_n=2'b11, bus_doe=0 and ack=0.
- R2: An accepted request gives exactly 1 clock with the qualifier active before the strobe, then a strobe of 1+2*W clocks (W = cfg_wr_ws for writes, cfg_rd_ws for reads), then exactly 1 qualifier clock after the strobe. ack pulses for one clock in the first clock after the qualifier is released.
- R3: cfg_qual selects the qualifier. 2'b01 uses only bus_ale, and bus_cs_n stays 1. 2'b11 drives both, with bus_ale equal to ~bus_cs_n. Any other value uses only bus_cs_n, and bus_ale stays 0.
- R4: In 8-bit mode (cfg_mode16=0) the byte at lane L=req_addr[1:0] of req_wdata is transferred. It is driven on bus_dout[7:0] when cfg_word=0, and on bus_dout[8L+7:8L] when cfg_word=1. All other output bits are 0.
- R5: In 16-bit mode the half-word H=req_addr[1] of req_wdata is driven on bus_dout[15:0] when cfg_word=0, and on bus_dout[16H+15:16H] when cfg_word=1. All other output bits are 0.
- R6: In 16-bit mode with cfg_bsel_en=1, bus_bsel_n equals ~req_be[2H+1:2H] for the whole qualifier period (bit 0 = lower byte). In all other cases it stays 2'b11.
- R7: In 16-bit mode with cfg_bsel_en=0, a request whose req_be[2H+1:2H] has exactly one bit set is answered by ack together with err=1, one clock after acceptance, and produces no qualifier or strobe.
- R8: A read returns the byte or half-word that is sampled from bus_din on the last strobe clock, taken from the same lanes a write would use. It is placed at lane L (8-bit) or H (16-bit) of rdata. In 16-bit mode with byte selects enabled, bytes whose req_be bit is 0 read as 0.
- R9: bus_doe is 1 only from the start of a write's qualifier period through its hold clock, and is never 1 during a read.
- R10: After a cycle, bus_addr and bus_dout keep their last values while the bus is idle.
- R11: With cfg_fifo=1, a write is not started while fifo_full=1 and a read is not started while fifo_empty=1. The qualifier appears in the clock after the blocking flag is sampled low. With cfg_fifo=0, both flags are ignored.
- R12: bus_wr_n and bus_rd_n are never low together, and a strobe is low only while the qualifier is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode16 | input | 1 | 1 = 16-bit data, 0 = 8-bit |
| cfg_word | input | 1 | Natural-lane steering enable |
| cfg_bsel_en | input | 1 | Byte-select enable (16-bit mode) |
| cfg_qual | input | 2 | Qualifier select (01 ALE, 11 both, else CSn) |
| cfg_fifo | input | 1 | FIFO-paced sub-mode enable |
| cfg_rd_ws | input | WS_W | Read wait states |
| cfg_wr_ws | input | WS_W | Write wait states |
| req | input | 1 | Request, held until ack |
| req_we | input | 1 | 1 = write |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 32 | Write data, in natural lanes |
| req_be | input | 4 | Byte enables |
| ack | output | 1 | One-clock completion pulse |
| err | output | 1 | Rejected request, valid with ack |
| rdata | output | 32 | Read data, valid with ack |
| bus_addr | output | ADDR_W | External address |
| bus_dout | output | 32 | External data out |
| bus_doe | output | 1 | External data output enable |
| bus_din | input | 32 | External data in |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_ale | output | 1 | Address latch enable |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_bsel_n | output | 2 | Active-low byte selects |
| fifo_full | input | 1 | External FIFO full flag |
| fifo_empty | input | 1 | External FIFO empty flag |

## Verification
The hardest situation to reach is a FIFO stall. The request has to be accepted and parked while the blocking flag is held. The flag must then drop on a known clock, and the stall length and the launch clock are checked from that point. Directed cases issue a write against a held full flag and a read against a held empty flag in parallel with a timed release, and count the idle clocks. Random cases turn the FIFO sub-mode off and toggle both flags, and then require zero idle clocks before launch. Randomized configurations cover every qualifier, lane, byte-select and wait-state combination, and the cases that are rejected as errors.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int BUS_W = 32;
  localparam int NLANE = BUS_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FWAIT,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } hb_state_e;

  localparam logic [1:0] QUAL_ALE  = 2'b01;
  localparam logic [1:0] QUAL_BOTH = 2'b11;
endpackage

// File: rtl/hb_lane_steer.sv
module hb_lane_steer
  import hb_pkg::*;
(
  input  logic             mode16,
  input  logic             word,
  input  logic             bsel_en,
  input  logic [1:0]       addr_lo,
  input  logic [BUS_W-1:0] wdata,
  input  logic [NLANE-1:0] be,
  output logic [BUS_W-1:0] dout,
  output logic [1:0]       bsel_n,
  output logic             bad
);
  logic [7:0]  sel_byte;
  logic [15:0] sel_half;
  logic [1:0]  be_half;

  always_comb begin
    sel_byte = wdata[{addr_lo, 3'b000} +: 8];
    sel_half = wdata[{addr_lo[1], 4'b0000} +: 16];
    be_half  = be[{addr_lo[1], 1'b0} +: 2];
    if (mode16) begin
      dout   = word ? ({16'b0, sel_half} << {addr_lo[1], 4'b0000}) : {16'b0, sel_half};
      bsel_n = bsel_en ? ~be_half : 2'b11;
      bad    = !bsel_en && (be_half == 2'b01 || be_half == 2'b10);
    end else begin
      dout   = word ? ({24'b0, sel_byte} << {addr_lo, 3'b000}) : {24'b0, sel_byte};
      bsel_n = 2'b11;
      bad    = 1'b0;
    end
  end
endmodule

// File: rtl/hb_rd_align.sv
module hb_rd_align
  import hb_pkg::*;
(
  input  logic             mode16,
  input  logic             word,
  input  logic             bsel_en,
  input  logic [1:0]       addr_lo,
  input  logic [NLANE-1:0] be,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] rd
);
  logic [7:0]  src_byte;
  logic [15:0] src_half;
  logic [1:0]  keep;

  always_comb begin
    src_byte = word ? din[{addr_lo, 3'b000} +: 8] : din[7:0];
    src_half = word ? din[{addr_lo[1], 4'b0000} +: 16] : din[15:0];
    keep     = bsel_en ? be[{addr_lo[1], 1'b0} +: 2] : 2'b11;
    if (mode16)
      rd = {16'b0, src_half & {{8{keep[1]}}, {8{keep[0]}}}} << {addr_lo[1], 4'b0000};
    else
      rd = {24'b0, src_byte} << {addr_lo, 3'b000};
  end
endmodule

// File: rtl/hb_strobe_cnt.sv
module hb_strobe_cnt #(
  parameter int WS_W = 2,
  localparam int CW  = WS_W + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [WS_W-1:0] ws,
  output logic            done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= CW'({ws, 1'b0});
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/hostbus_master.sv
module hostbus_master
  import hb_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WS_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_mode16,
  input  logic              cfg_word,
  input  logic              cfg_bsel_en,
  input  logic [1:0]        cfg_qual,
  input  logic              cfg_fifo,
  input  logic [WS_W-1:0]   cfg_rd_ws,
  input  logic [WS_W-1:0]   cfg_wr_ws,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic [NLANE-1:0]  req_be,
  output logic              ack,
  output logic              err,
  output logic [BUS_W-1:0]  rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BUS_W-1:0]  bus_dout,
  output logic              bus_doe,
  input  logic [BUS_W-1:0]  bus_din,
  output logic              bus_cs_n,
  output logic              bus_ale,
  output logic              bus_wr_n,
  output logic              bus_rd_n,
  output logic [1:0]        bus_bsel_n,
  input  logic              fifo_full,
  input  logic              fifo_empty
);
  hb_state_e state;

  // latched request
  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [BUS_W-1:0]  r_wdata;
  logic [NLANE-1:0]  r_be;

  // request source: live port in idle, latched copy otherwise
  logic              s_idle;
  logic              s_we;
  logic [ADDR_W-1:0] s_addr;
  logic [BUS_W-1:0]  s_wdata;
  logic [NLANE-1:0]  s_be;

  assign s_idle  = (state == ST_IDLE);
  assign s_we    = s_idle ? req_we    : r_we;
  assign s_addr  = s_idle ? req_addr  : r_addr;
  assign s_wdata = s_idle ? req_wdata : r_wdata;
  assign s_be    = s_idle ? req_be    : r_be;

  logic [BUS_W-1:0] st_dout;
  logic [1:0]       st_bsel_n;
  logic             st_bad;
  logic [BUS_W-1:0] rd_aligned;
  logic             cnt_load;
  logic             cnt_done;
  logic             blocked;
  logic             use_cs;
  logic             use_ale;

  hb_lane_steer u_steer (
    .mode16  (cfg_mode16),
    .word    (cfg_word),
    .bsel_en (cfg_bsel_en),
    .addr_lo (s_addr[1:0]),
    .wdata   (s_wdata),
    .be      (s_be),
    .dout    (st_dout),
    .bsel_n  (st_bsel_n),
    .bad     (st_bad)
  );

  hb_rd_align u_align (
    .mode16  (cfg_mode16),
    .word    (cfg_word),
    .bsel_en (cfg_bsel_en),
    .addr_lo (r_addr[1:0]),
    .be      (r_be),
    .din     (bus_din),
    .rd      (rd_aligned)
  );

  hb_strobe_cnt #(.WS_W(WS_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .load (cnt_load),
    .ws   (r_we ? cfg_wr_ws : cfg_rd_ws),
    .done (cnt_done)
  );

  assign cnt_load = (state == ST_SETUP);
  assign blocked  = cfg_fifo && (s_we ? fifo_full : fifo_empty);
  assign use_ale  = (cfg_qual == QUAL_ALE) || (cfg_qual == QUAL_BOTH);
  assign use_cs   = (cfg_qual != QUAL_ALE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      r_we       <= 1'b0;
      r_addr     <= '0;
      r_wdata    <= '0;
      r_be       <= '0;
      ack        <= 1'b0;
      err        <= 1'b0;
      rdata      <= '0;
      bus_addr   <= '0;
      bus_dout   <= '0;
      bus_doe    <= 1'b0;
      bus_cs_n   <= 1'b1;
      bus_ale    <= 1'b0;
      bus_wr_n   <= 1'b1;
      bus_rd_n   <= 1'b1;
      bus_bsel_n <= 2'b11;
    end else begin
      ack <= 1'b0;
      err <= 1'b0;
      case (state)
        ST_IDLE, ST_FWAIT: begin
          if (s_idle && req && !ack) begin
            r_we    <= req_we;
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
            r_be    <= req_be;
          end
          if ((s_idle && req && !ack) || !s_idle) begin
            if (s_idle && st_bad) begin
              ack <= 1'b1;
              err <= 1'b1;
            end else if (blocked) begin
              state <= ST_FWAIT;
            end else begin
              state      <= ST_SETUP;
              bus_addr   <= s_addr;
              bus_dout   <= st_dout;
              bus_doe    <= s_we;
              bus_bsel_n <= st_bsel_n;
              bus_cs_n   <= !use_cs;
              bus_ale    <= use_ale;
            end
          end
        end
        ST_SETUP: begin
          state    <= ST_STROBE;
          bus_wr_n <= !r_we;
          bus_rd_n <= r_we;
        end
        ST_STROBE: begin
          if (cnt_done) begin
            bus_wr_n <= 1'b1;
            bus_rd_n <= 1'b1;
            if (!r_we) rdata <= rd_aligned;
            state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          bus_cs_n   <= 1'b1;
          bus_ale    <= 1'b0;
          bus_doe    <= 1'b0;
          bus_bsel_n <= 2'b11;
          ack        <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Assertions
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!bus_wr_n && !bus_rd_n)); // R12

  AST_STROBE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr_n || !bus_rd_n) |-> (!bus_cs_n || bus_ale)); // R12

  AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> bus_rd_n); // R9

  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && $past(state) == ST_IDLE) |-> ($stable(bus_addr) && $stable(bus_dout))); // R10

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err |-> (ack && bus_cs_n && !bus_ale && bus_wr_n && bus_rd_n)); // R7

  AST_FIFO_WR_GATE: assert property (@(posedge clk) disable iff (rst)
    (cfg_fifo && $fell(bus_wr_n) && $past(state, 2) != ST_HOLD) |-> !$past(fifo_full, 2)); // R11
endmodule

// File: tb/sim_hostbus_master.sv
`timescale 1ns/1ps
module sim_hostbus_master;
  localparam int AW = 20;
  localparam int WW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_mode16 = 0, cfg_word = 0, cfg_bsel_en = 0, cfg_fifo = 0;
  logic [1:0] cfg_qual = 2'b00;
  logic [WW-1:0] cfg_rd_ws = '0, cfg_wr_ws = '0;
  logic req = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_be = '0;
  logic ack, err;
  logic [31:0] rdata;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_dout;
  logic bus_doe;
  logic [31:0] bus_din = '0;
  logic bus_cs_n, bus_ale, bus_wr_n, bus_rd_n;
  logic [1:0] bus_bsel_n;
  logic fifo_full = 0, fifo_empty = 0;

  always #4 clk = ~clk;

  hostbus_master #(.ADDR_W(AW), .WS_W(WW)) u0 (
    .clk(clk), .rst(rst), .cfg_mode16(cfg_mode16), .cfg_word(cfg_word),
    .cfg_bsel_en(cfg_bsel_en), .cfg_qual(cfg_qual), .cfg_fifo(cfg_fifo),
    .cfg_rd_ws(cfg_rd_ws), .cfg_wr_ws(cfg_wr_ws), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .ack(ack),
    .err(err), .rdata(rdata), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .bus_cs_n(bus_cs_n), .bus_ale(bus_ale),
    .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_bsel_n(bus_bsel_n),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty));

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // expected-value functions, built from the requirements
  function automatic logic [31:0] f_dout(bit m16, bit wd, logic [1:0] a, logic [31:0] w);
    logic [31:0] r = '0;
    int unsigned src, dst;
    if (m16) begin
      src = a[1]; dst = wd ? src : 0;
      for (int i = 0; i < 16; i++) r[16*dst + i] = w[16*src + i];
    end else begin
      src = a; dst = wd ? src : 0;
      for (int i = 0; i < 8; i++) r[8*dst + i] = w[8*src + i];
    end
    return r;
  endfunction

  function automatic logic [31:0] f_rdata(bit m16, bit wd, bit bs, logic [1:0] a, logic [3:0] be, logic [31:0] d);
    logic [31:0] r = '0;
    int unsigned dst, src;
    if (m16) begin
      dst = a[1]; src = wd ? dst : 0;
      for (int b = 0; b < 2; b++)
        if (!bs || be[2*dst + b])
          for (int i = 0; i < 8; i++) r[16*dst + 8*b + i] = d[16*src + 8*b + i];
    end else begin
      dst = a; src = wd ? dst : 0;
      for (int i = 0; i < 8; i++) r[8*dst + i] = d[8*src + i];
    end
    return r;
  endfunction

  function automatic logic [1:0] f_bsel(bit m16, bit bs, logic [1:0] a, logic [3:0] be);
    if (m16 && bs) return ~(a[1] ? be[3:2] : be[1:0]);
    return 2'b11;
  endfunction

  function automatic bit f_bad(bit m16, bit bs, logic [1:0] a, logic [3:0] be);
    logic [1:0] h = a[1] ? be[3:2] : be[1:0];
    return m16 && !bs && (h == 2'b01 || h == 2'b10);
  endfunction

  // results of the last transfer
  int t_wait, t_pre, t_stb, t_post, t_qbad, t_doe_bad, t_oth, t_bsel_bad;
  logic [AW-1:0] t_addr;
  logic [31:0] t_dout, t_rdata;
  logic t_doe, t_err, t_ack;
  logic [1:0] t_bsel;

  task automatic xfer(input bit we, input logic [AW-1:0] a, input logic [31:0] wd, input logic [3:0] be);
    bit q, s, o;
    t_wait = 0; t_pre = 0; t_stb = 0; t_post = 0; t_qbad = 0; t_doe_bad = 0;
    t_oth = 0; t_bsel_bad = 0; t_ack = 0; t_err = 0;
    @(negedge clk);
    req = 1; req_we = we; req_addr = a; req_wdata = wd; req_be = be;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (ack) begin
        t_ack = 1; t_err = err; t_rdata = rdata;
        req = 0;
        break;
      end
      q = (cfg_qual == 2'b01) ? bus_ale : !bus_cs_n;
      if (cfg_qual == 2'b01 && !bus_cs_n) t_qbad++;
      if (cfg_qual == 2'b11 && bus_ale != !bus_cs_n) t_qbad++;
      if (cfg_qual != 2'b01 && cfg_qual != 2'b11 && bus_ale) t_qbad++;
      s = we ? !bus_wr_n : !bus_rd_n;
      o = we ? !bus_rd_n : !bus_wr_n;
      if (o) t_oth++;
      if (q && bus_doe != we) t_doe_bad++;
      if (!q && bus_doe) t_doe_bad++;
      if (q && bus_bsel_n != f_bsel(cfg_mode16, cfg_bsel_en, a[1:0], be)) t_bsel_bad++;
      if (s) begin
        if (t_stb == 0) begin
          t_addr = bus_addr; t_dout = bus_dout; t_doe = bus_doe; t_bsel = bus_bsel_n;
        end
        t_stb++;
      end else if (q) begin
        if (t_stb == 0) t_pre++; else t_post++;
      end else if (t_stb == 0) t_wait++;
    end
  endtask

  task automatic run_and_check(input bit we, input logic [AW-1:0] a, input logic [31:0] wd,
                               input logic [3:0] be, input int exp_wait);
    int ws;
    bit bad;
    ws = we ? int'(cfg_wr_ws) : int'(cfg_rd_ws);
    bad = f_bad(cfg_mode16, cfg_bsel_en, a[1:0], be);
    xfer(we, a, wd, be);
    chk(t_ack == 1, "R2 ack seen", t_ack, 1);
    if (bad) begin
      chk(t_err == 1, "R7 err flagged", t_err, 1);
      chk(t_pre + t_stb + t_post + t_wait == 0, "R7 no bus cycle", t_pre + t_stb + t_post, 0);
      return;
    end
    chk(t_err == 0, "R7 no err", t_err, 0);
    chk(t_wait == exp_wait, "R11 launch delay", t_wait, exp_wait);
    chk(t_pre == 1 && t_post == 1, "R2 setup/hold", {t_pre[15:0], t_post[15:0]}, 32'h0001_0001);
    chk(t_stb == 1 + 2*ws, "R2 strobe width", t_stb, 1 + 2*ws);
    chk(t_qbad == 0, "R3 qualifier select", t_qbad, 0);
    chk(t_oth == 0, "R12 other strobe quiet", t_oth, 0);
    chk(t_doe_bad == 0, "R9 output enable", t_doe_bad, 0);
    chk(t_bsel_bad == 0, "R6 byte selects", t_bsel_bad, 0);
    chk(t_addr == a, "R10 address", t_addr, a);
    if (we)
      chk(t_dout == f_dout(cfg_mode16, cfg_word, a[1:0], wd),
          cfg_mode16 ? "R5 write lanes" : "R4 write lanes", t_dout, f_dout(cfg_mode16, cfg_word, a[1:0], wd));
    else
      chk(t_rdata == f_rdata(cfg_mode16, cfg_word, cfg_bsel_en, a[1:0], be, bus_din),
          "R8 read data", t_rdata, f_rdata(cfg_mode16, cfg_word, cfg_bsel_en, a[1:0], be, bus_din));
    repeat (2) @(negedge clk);
    chk(bus_addr == t_addr && bus_dout == t_dout && bus_cs_n && !bus_ale,
        "R10 idle hold", bus_addr, t_addr);
  endtask

  initial begin
    void'($urandom(32'h1D5EED));
    repeat (3) @(negedge clk);
    chk(bus_cs_n && !bus_ale && bus_wr_n && bus_rd_n && bus_bsel_n == 2'b11 && !bus_doe && !ack,
        "R1 reset state", {bus_cs_n, bus_ale, bus_wr_n, bus_rd_n, bus_bsel_n, bus_doe, ack}, 8'b1011_1100);
    rst = 0;
    @(negedge clk);

    // directed: longest wait states, 8-bit, both qualifiers
    cfg_qual = 2'b11; cfg_wr_ws = 3; cfg_rd_ws = 1;
    run_and_check(1, 20'h00003, 32'hA1B2C3D4, 4'h8, 0);
    bus_din = 32'h11223344;
    run_and_check(0, 20'h00002, 32'h0, 4'h4, 0);

    // directed: R7 rejected byte access in 16-bit mode without selects
    cfg_mode16 = 1; cfg_bsel_en = 0; cfg_qual = 2'b00;
    run_and_check(1, 20'h00010, 32'h5555AAAA, 4'b0001, 0);

    // directed: R11 write stalls on full, read stalls on empty
    cfg_mode16 = 0; cfg_fifo = 1; cfg_wr_ws = 0; cfg_rd_ws = 0;
    fifo_full = 1;
    fork
      run_and_check(1, 20'h00021, 32'hCAFEBABE, 4'h2, 10);
      begin @(negedge clk); repeat (10) @(negedge clk); fifo_full = 0; end
    join
    fifo_empty = 1;
    fork
      run_and_check(0, 20'h00030, 32'h0, 4'h1, 6);
      begin @(negedge clk); repeat (6) @(negedge clk); fifo_empty = 0; end
    join
    // R11 flag of the other direction does not hold back
    fifo_empty = 1;
    run_and_check(1, 20'h00044, 32'h01020304, 4'h1, 0);
    fifo_empty = 0; cfg_fifo = 0;

    // constrained random, FIFO pacing off, flags toggling and ignored (R11)
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      cfg_mode16  = $urandom_range(0, 1);
      cfg_word    = $urandom_range(0, 1);
      cfg_bsel_en = $urandom_range(0, 1);
      cfg_qual    = 2'($urandom_range(0, 3));
      cfg_rd_ws   = WW'($urandom_range(0, 3));
      cfg_wr_ws   = WW'($urandom_range(0, 3));
      fifo_full   = $urandom_range(0, 1);
      fifo_empty  = $urandom_range(0, 1);
      bus_din     = $urandom;
      run_and_check($urandom_range(0, 1), AW'($urandom), $urandom, 4'($urandom), 0);
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule